// File: doc/BRIEF.md
# Tagged Multi-Line Receive Silo

This block gathers characters from eight independent receiver lines into one shared FIFO. Each line hands over a complete parallel character together with parity-error and framing-error strobes. A one-slot holding register per line keeps the character until a round-robin scanner reaches that line. The scanner looks at one line per clock. Every stored entry is tagged with the number of its source line and with its error flags.

Software reads the whole FIFO through one 16-bit receive word. Each read request pops one entry. The top bit of the word is set only when the word carries a character, so software can treat a negative value as "data present". A small control register holds four bits:

- a self-clearing clear command;
- scan enable;
- receive-interrupt enable;
- fill-alarm enable.

With the fill alarm off, the interrupt signals that characters are waiting. With it on, the interrupt signals that a batch of characters has built up since the last read.

Top module: `tagged_rx_silo`

## Requirements
- R1: After `rst`, `rbuf_q`, `csr_q` and `irq` are all zero.
- R2: A pulse on `rbuf_rd` updates `rbuf_q` at the next clock edge. `rbuf_q` keeps its value in cycles without a read. A read of an empty FIFO returns 16'h0000.
- R3: A character word holds the following fields:
  - bit 15 = 1 (character present);
  - bit 14 = overrun;
  - bit 13 = framing error;
  - bit 12 = parity error;
  - bit 11 = 0;
  - bits 10:8 = source line number;
  - bits 7:0 = the character.
- R4: A write to `csr_wdata` stores the following control bits. `csr_q` shows them at the same positions, and all other bits of `csr_q` read 0.
  - bit 4 = clear;
  - bit 5 = scan enable;
  - bit 6 = receive-interrupt enable;
  - bit 12 = fill-alarm enable.
- R5: While scan enable is 0, line arrivals are not captured and the scanner does not move.
- R6: Scanning works as follows:
  - After reset or clear, the scanner points at line 0.
  - At each clock edge with scan enable set, the scanner examines its line, stores that line's held character if one is held, and then steps to the next line, wrapping after line 7.
  - An arrival is captured at the edge where its strobe is high. That character is stored the next time the scanner examines its line.
- R7: The FIFO holds 64 entries and returns them in the order they were stored.
- R8: A character the scanner reaches while the FIFO is full and no read is under way is discarded. The next entry stored after the loss has bit 14 set.
- R9: A read and a scanner store in the same cycle on a full FIFO both succeed, and no character is discarded.
- R10: A new arrival on a line whose previous character is still held is discarded, and the held character is kept. The next entry stored afterwards has bit 14 set.
- R11: With fill-alarm enable at 0, `irq` is registered and equals receive-interrupt enable AND (FIFO not empty). `irq` is 0 whenever receive-interrupt enable is 0.
- R12: With fill-alarm enable at 1, `irq` rises only after 16 entries have been stored since the last read. Any read restarts this count.
- R13: Writing bit 4 makes `csr_q` read 16'h0010 for one cycle. After that cycle all state is reset: FIFO empty, control bits 0, scanner at line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Control register write strobe |
| csr_wdata | input | 16 | Control register write value |
| csr_q | output | 16 | Control register read value |
| rbuf_rd | input | 1 | Receive word read (pop) strobe |
| rbuf_q | output | 16 | Receive word, updated on read |
| line_vld | input | 8 | Per-line character strobe |
| line_data | input | 64 | Per-line characters, line i in bits 8i+7:8i |
| line_perr | input | 8 | Per-line parity error with the strobe |
| line_ferr | input | 8 | Per-line framing error with the strobe |
| irq | output | 1 | Receive interrupt request |

## Verification
The delicate collision is a read that pops the FIFO at the same clock edge where the scanner stores into a completely full FIFO. The bench tracks the scanner position from the cycle in which scan enable was set. It fills the FIFO to 64 entries, arranges a single held character, and raises the read strobe exactly for the edge at which the scanner reaches that line. It then judges the outcome from the popped word and from a full drain. The drain must show the new character at the tail. It must also show no overrun flag, which would have appeared if the store had been rejected.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int CHAR_W = 8;
  localparam int TAG_W  = 3;
  localparam int WORD_W = 16;

  localparam int BIT_CLR = 4;
  localparam int BIT_MSE = 5;
  localparam int BIT_RIE = 6;
  localparam int BIT_SAE = 12;

  typedef struct packed {
    logic              ovr;
    logic              ferr;
    logic              perr;
    logic [TAG_W-1:0]  line;
    logic [CHAR_W-1:0] data;
  } entry_t;

  function automatic logic [WORD_W-1:0] pack_word(logic present, entry_t e);
    return {present, e.ovr, e.ferr, e.perr, 1'b0, e.line, e.data};
  endfunction
endpackage

// File: rtl/rxs_line_slot.sv
module rxs_line_slot
  import rxs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              in_vld,
  input  logic [CHAR_W-1:0] in_data,
  input  logic              in_perr,
  input  logic              in_ferr,
  input  logic              take,
  output logic              pending,
  output logic [CHAR_W-1:0] hold_data,
  output logic              hold_perr,
  output logic              hold_ferr,
  output logic              lost
);
  logic accept;

  // An arrival is lost only if the slot stays occupied through this edge.
  assign lost   = en & in_vld & pending & ~take;
  assign accept = en & in_vld & ~lost;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending   <= 1'b0;
      hold_data <= '0;
      hold_perr <= 1'b0;
      hold_ferr <= 1'b0;
    end else begin
      if (take)
        pending <= 1'b0;
      if (accept) begin
        pending   <= 1'b1;
        hold_data <= in_data;
        hold_perr <= in_perr;
        hold_ferr <= in_ferr;
      end
    end
  end

  AST_SLOT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!en && !pending) |=> !pending); // R5
endmodule

// File: rtl/rxs_scanner.sv
module rxs_scanner
  import rxs_pkg::*;
#(
  parameter int LINES = 8
)(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [LINES-1:0]        pend,
  input  logic [LINES*CHAR_W-1:0] data_bus,
  input  logic [LINES-1:0]        perr_v,
  input  logic [LINES-1:0]        ferr_v,
  output logic [LINES-1:0]        take,
  output logic                    req,
  output entry_t                  cand
);
  localparam int PTR_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(LINES - 1);

  logic [PTR_W-1:0] ptr;

  always_ff @(posedge clk) begin
    if (rst)
      ptr <= '0;
    else if (en)
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  always_comb begin
    req       = en & pend[ptr];
    take      = '0;
    take[ptr] = req;
    cand.ovr  = 1'b0;
    cand.ferr = ferr_v[ptr];
    cand.perr = perr_v[ptr];
    cand.line = TAG_W'(ptr);
    cand.data = data_bus[ptr*CHAR_W +: CHAR_W];
  end

  AST_SCAN_HALT: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(ptr)); // R5
  AST_ONE_TAKE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(take)); // R6
endmodule

// File: rtl/rxs_fifo.sv
module rxs_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 14
)(
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_req,
  output logic [W:0]   rd_word,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_rd;

  assign full  = (cnt == FULL_CNT);
  assign empty = (cnt == '0);
  assign do_rd = rd_req & ~empty;

  always_ff @(posedge clk) begin
    if (wr_en)
      mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_word <= '0;
    else if (rd_req)
      rd_word <= do_rd ? {1'b1, mem[rp]} : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_en) wp <= wp + 1'b1;
      if (do_rd) rp <= rp + 1'b1;
      case ({wr_en, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (!full || rd_req)); // R9
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL_CNT); // R7
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_req && empty) |=> (rd_word == '0)); // R2
endmodule

// File: rtl/tagged_rx_silo.sv
module tagged_rx_silo
  import rxs_pkg::*;
#(
  parameter int LINES = 8,
  parameter int DEPTH = 64,
  parameter int ALARM = 16
)(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    csr_wr,
  input  logic [WORD_W-1:0]       csr_wdata,
  output logic [WORD_W-1:0]       csr_q,
  input  logic                    rbuf_rd,
  output logic [WORD_W-1:0]       rbuf_q,
  input  logic [LINES-1:0]        line_vld,
  input  logic [LINES*CHAR_W-1:0] line_data,
  input  logic [LINES-1:0]        line_perr,
  input  logic [LINES-1:0]        line_ferr,
  output logic                    irq
);
  localparam int EW = $bits(entry_t);
  localparam int CW = $clog2(ALARM + 1);
  localparam logic [CW-1:0] ALARM_C = CW'(ALARM);

  logic mse, rie, sae, clr_q, srst;
  logic ovr_q;
  logic [CW-1:0] since_rd;

  logic [LINES-1:0]        pend_v, take_v, lost_v, perr_v, ferr_v;
  logic [LINES*CHAR_W-1:0] hold_bus;
  logic                    req, push_ok, drop;
  logic                    f_full, f_empty;
  logic [EW:0]             rd_word;
  entry_t                  cand, wr_e;

  wire unused_wbits = ^{csr_wdata[15:13], csr_wdata[11:7], csr_wdata[3:0]};

  assign srst = rst | clr_q;

  // control register; clear takes effect one cycle after it is written
  always_ff @(posedge clk) begin
    if (srst) begin
      mse   <= 1'b0;
      rie   <= 1'b0;
      sae   <= 1'b0;
      clr_q <= 1'b0;
    end else if (csr_wr) begin
      mse   <= csr_wdata[BIT_MSE];
      rie   <= csr_wdata[BIT_RIE];
      sae   <= csr_wdata[BIT_SAE];
      clr_q <= csr_wdata[BIT_CLR];
    end
  end

  always_comb begin
    csr_q          = '0;
    csr_q[BIT_CLR] = clr_q;
    csr_q[BIT_MSE] = mse;
    csr_q[BIT_RIE] = rie;
    csr_q[BIT_SAE] = sae;
  end

  for (genvar g = 0; g < LINES; g++) begin : g_slot
    rxs_line_slot u_slot (
      .clk       (clk),
      .rst       (srst),
      .en        (mse),
      .in_vld    (line_vld[g]),
      .in_data   (line_data[g*CHAR_W +: CHAR_W]),
      .in_perr   (line_perr[g]),
      .in_ferr   (line_ferr[g]),
      .take      (take_v[g]),
      .pending   (pend_v[g]),
      .hold_data (hold_bus[g*CHAR_W +: CHAR_W]),
      .hold_perr (perr_v[g]),
      .hold_ferr (ferr_v[g]),
      .lost      (lost_v[g])
    );
  end

  rxs_scanner #(.LINES(LINES)) u_scan (
    .clk      (clk),
    .rst      (srst),
    .en       (mse),
    .pend     (pend_v),
    .data_bus (hold_bus),
    .perr_v   (perr_v),
    .ferr_v   (ferr_v),
    .take     (take_v),
    .req      (req),
    .cand     (cand)
  );

  // a full FIFO still accepts when the same edge pops an entry
  assign push_ok = req & (~f_full | rbuf_rd);
  assign drop    = req & ~push_ok;

  always_comb begin
    wr_e     = cand;
    wr_e.ovr = ovr_q;
  end

  rxs_fifo #(.DEPTH(DEPTH), .W(EW)) u_fifo (
    .clk     (clk),
    .rst     (srst),
    .wr_en   (push_ok),
    .wr_data (wr_e),
    .rd_req  (rbuf_rd),
    .rd_word (rd_word),
    .full    (f_full),
    .empty   (f_empty)
  );

  assign rbuf_q = pack_word(rd_word[EW], entry_t'(rd_word[EW-1:0]));

  always_ff @(posedge clk) begin
    if (srst) begin
      ovr_q    <= 1'b0;
      since_rd <= '0;
      irq      <= 1'b0;
    end else begin
      ovr_q <= (ovr_q & ~push_ok) | drop | (|lost_v);
      if (rbuf_rd)
        since_rd <= push_ok ? CW'(1) : '0;
      else if (push_ok && since_rd != ALARM_C)
        since_rd <= since_rd + 1'b1;
      irq <= rie & (sae ? (since_rd == ALARM_C) : ~f_empty);
    end
  end

  AST_CLR_SELF: assert property (@(posedge clk) disable iff (rst)
    clr_q |=> (!clr_q && csr_q == '0)); // R13
  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (rst)
    !rie |=> !irq); // R11
endmodule

// File: tb/sim_tagged_rx_silo.sv
module sim_tagged_rx_silo;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_wr = 1'b0;
  logic [15:0] csr_wdata = '0;
  logic [15:0] csr_q;
  logic        rbuf_rd = 1'b0;
  logic [15:0] rbuf_q;
  logic [7:0]  line_vld = '0;
  logic [63:0] line_data = '0;
  logic [7:0]  line_perr = '0;
  logic [7:0]  line_ferr = '0;
  logic        irq;

  int nvec = 0;
  int nerr = 0;
  int cyc  = 0;
  int wref = 0;
  logic [15:0] eq [0:255];
  int eh = 0;
  int et = 0;

  tagged_rx_silo u0 (
    .clk(clk), .rst(rst), .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_q(csr_q),
    .rbuf_rd(rbuf_rd), .rbuf_q(rbuf_q), .line_vld(line_vld), .line_data(line_data),
    .line_perr(line_perr), .line_ferr(line_ferr), .irq(irq)
  );

  always #2ns clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mkw(logic ovr, logic fe, logic pe, int ln, logic [7:0] d);
    return {1'b1, ovr, fe, pe, 1'b0, 3'(ln), d};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic csr_write(input logic [15:0] v);
    csr_wr = 1'b1; csr_wdata = v;
    @(negedge clk);
    csr_wr = 1'b0; csr_wdata = '0;
  endtask

  task automatic rd(output logic [15:0] w);
    rbuf_rd = 1'b1;
    @(negedge clk);
    rbuf_rd = 1'b0;
    w = rbuf_q;
  endtask

  task automatic wait_line(input int ln);
    while (((cyc - wref) % 8) != ln) @(negedge clk);
  endtask

  task automatic arrive(input logic [7:0] m, input logic [7:0] base,
                        input logic [7:0] pm, input logic [7:0] fm);
    for (int i = 0; i < 8; i++) line_data[i*8 +: 8] = base + 8'(i);
    line_vld = m; line_perr = pm; line_ferr = fm;
    @(negedge clk);
    line_vld = '0; line_perr = '0; line_ferr = '0;
  endtask

  // record expected entries in scan order (R6), then present the burst
  task automatic burst(input logic [7:0] m, input logic [7:0] base,
                       input logic [7:0] pm, input logic [7:0] fm);
    int s;
    s = (cyc - wref) % 8;
    for (int k = 0; k < 8; k++) begin
      int ln;
      ln = (s + 1 + k) % 8;
      if (m[ln]) begin
        eq[et] = mkw(1'b0, fm[ln], pm[ln], ln, base + 8'(ln));
        et++;
      end
    end
    arrive(m, base, pm, fm);
  endtask

  task automatic drain(input int n, input string req);
    logic [15:0] w;
    for (int i = 0; i < n; i++) begin
      rd(w);
      chk(req, w, eq[eh]);
      eh++;
    end
  endtask

  initial begin
    #(150000 * 4ns);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [15:0] w;
    tick(3);
    rst = 1'b0;
    tick(1);
    chk("R1 rbuf", rbuf_q, 16'h0);
    chk("R1 csr", csr_q, 16'h0);
    chk("R1 irq", {15'b0, irq}, 16'h0);

    csr_write(16'h0060);
    wref = cyc;
    chk("R4 csr readback", csr_q, 16'h0060);
    rd(w);
    chk("R2 empty read", w, 16'h0);
    tick(3);
    chk("R2 hold", rbuf_q, 16'h0);

    // R3 R6 field layout and scan order, errors on some lines
    wait_line(5);
    burst(8'hFF, 8'h10, 8'hAA, 8'hCC);
    tick(12);
    chk("R11 irq pending", {15'b0, irq}, 16'h1);
    drain(8, "R3 R6 word/order");
    rd(w);
    chk("R2 empty after drain", w, 16'h0);
    tick(2);
    chk("R11 irq idle", {15'b0, irq}, 16'h0);

    // R12 fill alarm
    csr_write(16'h1060);
    chk("R4 alarm bit", csr_q, 16'h1060);
    burst(8'hFF, 8'h20, 8'h00, 8'h00);
    tick(12);
    burst(8'h7F, 8'h30, 8'h00, 8'h00);
    tick(12);
    chk("R12 below alarm", {15'b0, irq}, 16'h0);
    burst(8'h01, 8'h40, 8'h00, 8'h00);
    tick(12);
    chk("R12 at alarm", {15'b0, irq}, 16'h1);
    drain(1, "R12 first read");
    tick(2);
    chk("R12 read restarts count", {15'b0, irq}, 16'h0);
    drain(15, "R7 alarm drain");
    csr_write(16'h0060);

    // R7 fill to depth
    for (int b = 0; b < 8; b++) begin
      burst(8'hFF, 8'(8 * b), 8'h00, 8'h00);
      tick(10);
    end
    // R9 pop and store at the same edge on a full FIFO
    wait_line(2);
    arrive(8'h04, 8'hC0, 8'h00, 8'h00);
    wait_line(2);
    rd(w);
    chk("R9 pop at full", w, eq[eh]);
    eh++;
    eq[et] = mkw(1'b0, 1'b0, 1'b0, 2, 8'hC2);
    et++;
    tick(4);
    // R8 overflow drop
    arrive(8'hFF, 8'hE0, 8'h00, 8'h00);
    tick(12);
    drain(1, "R8 head after drop");
    arrive(8'h40, 8'h70, 8'h00, 8'h00);
    eq[et] = mkw(1'b1, 1'b0, 1'b0, 6, 8'h76);
    et++;
    tick(12);
    drain(64, "R7 R8 R9 full drain");
    rd(w);
    chk("R2 empty after full drain", w, 16'h0);

    // R10 second arrival on a held line
    wait_line(4);
    arrive(8'h08, 8'h2E, 8'h00, 8'h00);
    arrive(8'h08, 8'h2F, 8'h00, 8'h00);
    eq[et] = mkw(1'b1, 1'b0, 1'b0, 3, 8'h31);
    et++;
    tick(12);
    drain(1, "R10 held kept, overrun set");
    rd(w);
    chk("R10 second discarded", w, 16'h0);

    // R5 scan disabled
    csr_write(16'h0040);
    arrive(8'hFF, 8'h50, 8'h00, 8'h00);
    tick(12);
    rd(w);
    chk("R5 no capture while disabled", w, 16'h0);
    csr_write(16'h0060);
    tick(12);
    rd(w);
    chk("R5 nothing held after enable", w, 16'h0);

    // R13 clear
    arrive(8'hFF, 8'h60, 8'h00, 8'h00);
    tick(12);
    chk("R13 irq before clear", {15'b0, irq}, 16'h1);
    csr_write(16'h0010);
    chk("R13 clear visible", csr_q, 16'h0010);
    tick(1);
    chk("R13 clear self-clears", csr_q, 16'h0);
    tick(2);
    chk("R13 irq after clear", {15'b0, irq}, 16'h0);
    rd(w);
    chk("R13 FIFO emptied", w, 16'h0);

    // R11 interrupt masked
    csr_write(16'h0020);
    wref = cyc;
    arrive(8'h01, 8'h90, 8'h00, 8'h00);
    tick(12);
    chk("R11 irq masked", {15'b0, irq}, 16'h0);
    rd(w);
    chk("R6 after clear line 0", w, mkw(1'b0, 1'b0, 1'b0, 0, 8'h90));

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule